// File: doc/BRIEF.md
# Periodic Frame List Index and Entry Addresser

This block holds the 14-bit microframe counter of a high-speed USB host controller's periodic schedule. The counter advances once per microframe tick while the schedule runs. From the counter it derives the 11-bit frame number that goes into each start-of-frame token, and the index of the current periodic list entry. It also forms the byte address of that entry in system memory from a 4 kB-aligned list base. An optional upper segment supplies bits 63..32 of the address when 64-bit addressing is enabled.

Software loads the counter and the list base through two plain write strobes before it starts the schedule. The list size is a 2-bit code on a plain control input. The block has no streaming data path, so it has no valid/ready handshake and applies no back-pressure. Every input is sampled at each clock edge, and every output is a register.

Top module: `pfl_index_gen`

## Requirements
- R1: While rst_n is low, the counter and the stored base are zero. After release, with all inputs idle, sof_frame_o, list_idx_o and entry_addr_o read zero.
- R2: When run_i and uframe_tick_i are both high at an edge, and no counter write is present, the counter increases by one. In every other case it holds its value.
- R3: The counter wraps from 0x3FFF to 0x0000 on an advancing tick.
- R4: When idx_wr_i is high, the counter loads idx_wr_data_i at that edge, even if a tick is also present.
- R5: sof_frame_o equals counter bits 13..3, so it advances once every eight ticks.
- R6: list_idx_o is a slice of the counter that depends on size_sel_i, zero-extended to 10 bits. Code 00 gives bits 12..3 (1024 entries). Code 01 gives bits 11..3 (512 entries). Code 10 gives bits 10..3 (256 entries).
- R7: entry_addr_o[31:0] is the stored base bits 31..12, then list_idx_o, then two zero bits. The base register keeps only bits 31..12 of base_wr_data_i when base_wr_i is high, so bits 11..0 of a write have no effect.
- R8: The reserved code 11 on size_sel_i produces the same index as code 00 and drives size_err_o high. Every other code drives size_err_o low.
- R9: entry_addr_o[63:32] equals seg_hi_i when addr64_i is high, and zero otherwise.
- R10: All outputs are registered. They reflect a tick, a write or a change on size_sel_i, addr64_i or seg_hi_i at the same clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uframe_tick_i | input | 1 | One-cycle pulse at the end of each microframe |
| run_i | input | 1 | Schedule run enable; the counter advances only while it is high |
| idx_wr_i | input | 1 | Counter write strobe |
| idx_wr_data_i | input | 14 | Value loaded into the counter |
| base_wr_i | input | 1 | List base write strobe |
| base_wr_data_i | input | 32 | List base byte address; bits 11..0 are ignored |
| size_sel_i | input | 2 | List size code (00 = 1024, 01 = 512, 10 = 256, 11 = reserved) |
| addr64_i | input | 1 | Enables the upper address segment |
| seg_hi_i | input | 32 | Upper 32 address bits used in 64-bit mode |
| sof_frame_o | output | 11 | Frame number for the start-of-frame token |
| list_idx_o | output | 10 | Current periodic list index |
| entry_addr_o | output | 64 | Byte address of the current list entry |
| size_err_o | output | 1 | High while the reserved size code is selected |

## Verification
The bench runs the counter across the 0x3FFF boundary. A design that saturates there, or that carries into a fifteenth bit, would stop at 0x3FFF or fail to return to index zero. The bench asserts a write and a tick in the same cycle. If the write does not take priority, the result comes out one higher than the written value. The bench sweeps all four size codes over one counter value that has bits 12..10 set, so using the wrong slice width leaks high bits into the index, and a reserved code that is not handled yields a stray index or no error flag. The bench also writes a base with nonzero low bits and toggles 64-bit mode, which exposes low address bits that are not masked and upper address bits that are not gated off.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int CNT_W       = 14;
  localparam int SUB_BITS    = 3;
  localparam int SOF_W       = CNT_W - SUB_BITS;
  localparam int IDX_W       = 10;
  localparam int ADDR_W      = 32;
  localparam int BASE_LSB    = 12;
  localparam int BASE_W      = ADDR_W - BASE_LSB;
  localparam int ENTRY_SHIFT = 2;
  localparam int N_SIZES     = 3;

  typedef enum logic [1:0] {
    SZ_1024 = 2'b00,
    SZ_512  = 2'b01,
    SZ_256  = 2'b10,
    SZ_RSVD = 2'b11
  } list_size_e;
endpackage

// File: rtl/pfl_uframe_ctr.sv
module pfl_uframe_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv = run_i & tick_i;

  always_comb begin
    cnt_d_o = cnt_q;
    if (wr_en_i)  cnt_d_o = wr_data_i;
    else if (adv) cnt_d_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d_o;
  end

  assign cnt_q_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !(run_i && tick_i)) |=> $stable(cnt_q)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && run_i && tick_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && run_i && tick_i && cnt_q == CNT_MAX) |=> cnt_q == '0); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> cnt_q == $past(wr_data_i)); // R4
endmodule

// File: rtl/pfl_list_index.sv
module pfl_list_index
  import pfl_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int IDX_W    = 10,
  parameter int SUB_BITS = 3,
  parameter int N_SIZES  = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       size_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             err_o
);
  logic [IDX_W-1:0] cand [N_SIZES];

  // Candidate g halves the list g times: its slice loses g upper bits.
  for (genvar g = 0; g < N_SIZES; g++) begin : g_slice
    localparam int HI = SUB_BITS + IDX_W - 1 - g;
    assign cand[g] = IDX_W'(cnt_i[HI:SUB_BITS]);
  end

  always_comb begin
    err_o = 1'b0;
    unique case (list_size_e'(size_i))
      SZ_512:  idx_o = cand[1];
      SZ_256:  idx_o = cand[2];
      SZ_RSVD: begin
        idx_o = cand[0];
        err_o = 1'b1;
      end
      default: idx_o = cand[0];
    endcase
  end
endmodule

// File: rtl/pfl_addr_form.sv
module pfl_addr_form #(
  parameter int ADDR_W      = 32,
  parameter int BASE_W      = 20,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [BASE_W-1:0]   base_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                a64_i,
  input  logic [ADDR_W-1:0]   seg_i,
  output logic [2*ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] lo;
  logic [ADDR_W-1:0] hi;

  assign lo     = {base_i, idx_i, {ENTRY_SHIFT{1'b0}}};
  assign hi     = a64_i ? seg_i : '0;
  assign addr_o = {hi, lo};
endmodule

// File: rtl/pfl_index_gen.sv
module pfl_index_gen
  import pfl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                uframe_tick_i,
  input  logic                run_i,
  input  logic                idx_wr_i,
  input  logic [CNT_W-1:0]    idx_wr_data_i,
  input  logic                base_wr_i,
  input  logic [ADDR_W-1:0]   base_wr_data_i,
  input  logic [1:0]          size_sel_i,
  input  logic                addr64_i,
  input  logic [ADDR_W-1:0]   seg_hi_i,
  output logic [SOF_W-1:0]    sof_frame_o,
  output logic [IDX_W-1:0]    list_idx_o,
  output logic [2*ADDR_W-1:0] entry_addr_o,
  output logic                size_err_o
);
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BASE_W-1:0]   base_q, base_d;
  logic [IDX_W-1:0]    idx_d;
  logic                err_d;
  logic [2*ADDR_W-1:0] addr_d;

  pfl_uframe_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (uframe_tick_i),
    .run_i     (run_i),
    .wr_en_i   (idx_wr_i),
    .wr_data_i (idx_wr_data_i),
    .cnt_q_o   (cnt_q),
    .cnt_d_o   (cnt_d)
  );

  assign base_d = base_wr_i ? base_wr_data_i[ADDR_W-1:BASE_LSB] : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  pfl_list_index #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .SUB_BITS(SUB_BITS), .N_SIZES(N_SIZES)
  ) u_idx (
    .cnt_i  (cnt_d),
    .size_i (size_sel_i),
    .idx_o  (idx_d),
    .err_o  (err_d)
  );

  pfl_addr_form #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .IDX_W(IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_addr (
    .base_i (base_d),
    .idx_i  (idx_d),
    .a64_i  (addr64_i),
    .seg_i  (seg_hi_i),
    .addr_o (addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_frame_o  <= '0;
      list_idx_o   <= '0;
      entry_addr_o <= '0;
      size_err_o   <= 1'b0;
    end else begin
      sof_frame_o  <= cnt_d[CNT_W-1:SUB_BITS];
      list_idx_o   <= idx_d;
      entry_addr_o <= addr_d;
      size_err_o   <= err_d;
    end
  end

  AST_SOF_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_frame_o == cnt_q[CNT_W-1:SUB_BITS]); // R5
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    entry_addr_o[ENTRY_SHIFT-1:0] == '0); // R7
  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    size_sel_i == 2'b11 |=> size_err_o); // R8
  AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !addr64_i |=> entry_addr_o[2*ADDR_W-1:ADDR_W] == '0); // R9
endmodule

// File: tb/pfl_index_gen_bench.sv
`timescale 1ns/1ps
module pfl_index_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, run = 1'b0, iwr = 1'b0, bwr = 1'b0, a64 = 1'b0;
  logic [13:0] iwd = '0;
  logic [31:0] bwd = '0, seg = '0;
  logic [1:0]  sz = 2'b00;
  logic [10:0] sof;
  logic [9:0]  idx;
  logic [63:0] addr;
  logic        err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfl_index_gen u_pfl_index_gen (
    .clk(clk), .rst_n(rst_n), .uframe_tick_i(tick), .run_i(run),
    .idx_wr_i(iwr), .idx_wr_data_i(iwd), .base_wr_i(bwr), .base_wr_data_i(bwd),
    .size_sel_i(sz), .addr64_i(a64), .seg_hi_i(seg),
    .sof_frame_o(sof), .list_idx_o(idx), .entry_addr_o(addr), .size_err_o(err)
  );

  // Reference state, built from the requirements.
  logic [13:0] m_cnt = '0;
  logic [19:0] m_base = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      m_base <= '0;
    end else begin
      if (iwr)             m_cnt <= iwd;
      else if (run && tick) m_cnt <= m_cnt + 14'd1;
      if (bwr)             m_base <= bwd[31:12];
    end
  end

  function automatic logic [9:0] exp_idx(input logic [13:0] c, input logic [1:0] s);
    case (s)
      2'b01:   return {1'b0, c[11:3]};
      2'b10:   return {2'b00, c[10:3]};
      default: return c[12:3];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [9:0] ei;
    ei = exp_idx(m_cnt, sz);
    chk(req, "sof", 64'(sof), 64'(m_cnt[13:3]));
    chk(req, "idx", 64'(idx), 64'(ei));
    chk(req, "addr", addr, {(a64 ? seg : 32'h0), m_base, ei, 2'b00});
    chk(req, "err", 64'(err), 64'(sz == 2'b11));
  endtask

  // Apply inputs after a falling edge, let one rising edge sample them, then check at the next falling edge.
  task automatic cyc(input logic t, input logic w, input logic [13:0] d);
    tick = t; iwr = w; iwd = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; iwr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "sof at reset", 64'(sof), 64'h0);
    chk("R1", "addr at reset", addr, 64'h0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, '0);
    chk_all("R1");
  endtask

  task automatic t_count();
    run = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, '0);
      chk_all("R2");
      chk("R5", "sof after tick", 64'(sof), 64'((i + 1) / 8));
      chk("R10", "same-edge update", 64'(m_cnt), 64'(i + 1));
    end
  endtask

  task automatic t_hold();
    run = 1'b0;
    cyc(1'b1, 1'b0, '0);
    chk_all("R2");
    chk("R2", "no count without run", 64'(sof), 64'(20 / 8));
    run = 1'b1;
    cyc(1'b0, 1'b0, '0);
    chk_all("R2");
  endtask

  task automatic t_wrap();
    cyc(1'b0, 1'b1, 14'h3FFE);
    chk_all("R4");
    cyc(1'b1, 1'b0, '0);
    chk("R3", "sof at max", 64'(sof), 64'h7FF);
    cyc(1'b1, 1'b0, '0);
    chk("R3", "sof after wrap", 64'(sof), 64'h0);
    chk("R3", "idx after wrap", 64'(idx), 64'h0);
  endtask

  task automatic t_write_prio();
    cyc(1'b1, 1'b1, 14'h0123);
    chk("R4", "write beats tick", 64'(sof), 64'(14'h0123 >> 3));
    chk_all("R4");
  endtask

  task automatic t_sizes();
    cyc(1'b0, 1'b1, 14'h1FF8);
    for (int s = 0; s < 4; s++) begin
      sz = 2'(s);
      cyc(1'b0, 1'b0, '0);
      chk_all("R6");
    end
    chk("R8", "reserved idx", 64'(idx), 64'h3FF);
    chk("R8", "reserved flag", 64'(err), 64'h1);
    sz = 2'b10;
    cyc(1'b0, 1'b0, '0);
    chk("R6", "256 idx", 64'(idx), 64'hFF);
    chk("R8", "flag clear", 64'(err), 64'h0);
    sz = 2'b00;
  endtask

  task automatic t_base();
    bwd = 32'hABCD_EFFF;
    tick = 1'b0;
    bwr = 1'b1;
    cyc(1'b0, 1'b0, '0);
    bwr = 1'b0;
    chk("R7", "base low ignored", 64'(addr[31:12]), 64'h0ABCDE);
    chk_all("R7");
    cyc(1'b0, 1'b1, 14'h0008);
    chk("R7", "entry addr", addr, 64'hABCD_E004);
  endtask

  task automatic t_seg();
    seg = 32'h1234_5678;
    cyc(1'b0, 1'b0, '0);
    chk("R9", "upper gated", 64'(addr[63:32]), 64'h0);
    a64 = 1'b1;
    cyc(1'b0, 1'b0, '0);
    chk("R9", "upper segment", 64'(addr[63:32]), 64'h1234_5678);
    chk_all("R10");
    a64 = 1'b0;
    cyc(1'b0, 1'b0, '0);
    chk_all("R9");
  endtask

  initial begin
    t_reset();
    t_count();
    t_hold();
    t_wrap();
    t_write_prio();
    t_sizes();
    t_base();
    t_seg();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule